// File: doc/BRIEF.md
# Chip-Timing Linear Interpolator with Prompt and Early/Late Outputs

The block takes one rail (I or Q) of filtered baseband samples that arrive at four samples per chip and resamples them at two samples per chip by first-order interpolation between two neighbouring input samples. The sampling instant is chosen by a timing word from the chip timing tracker. The word has an integer delay, which selects how far back in a short history of input samples to reach, and a fractional epoch, which gives the blend point between the two chosen samples. The resampled epochs are numbered n = 0 .. 2L-1 within a symbol of L chips. Even epochs form the prompt stream and odd epochs, which fall midway between consecutive prompts, form the early/late stream. Each stream runs at chip rate and has its own one-cycle valid strobe. Two instances serve the I and Q rails.

A small sequencer sets the rhythm. In state FILL it consumes the first HIST_LEN accepted samples without producing output. After that it alternates between PAIR0, which waits for the first sample of a pair, and PAIR1, which waits for the second. Transitions: FILL to PAIR0 on the accepted sample that brings the fill count to HIST_LEN. PAIR0 to PAIR1 on any accepted sample. PAIR1 to PAIR0 on any accepted sample, which also fires an epoch. A timing word is taken only on the sample that fires epoch 0 of a symbol, so every epoch of a symbol uses the same word and no epoch is skipped or repeated.

Top module: `lin_interp`

## Requirements
- R1: While reset is held and right after it, prm_valid and el_valid are 0 and prm_data and el_data are 0.
- R2: The first HIST_LEN samples accepted after reset (in_valid high on a rising edge) produce no output strobe.
- R3: After the fill, every second accepted sample fires exactly one epoch. Cycles with in_valid low neither advance the pairing nor fire an epoch.
- R4: An epoch's value is older + floor((mu*(newer-older) + 2^(FRAC_W-1)) / 2^FRAC_W), where mu is the unsigned fractional epoch. This is round-half-up of older + mu/2^FRAC_W*(newer-older). The result is a signed SAMP_W-bit two's-complement value.
- R5: With h[0] the sample that fires the epoch and h[k] the sample accepted k samples before it, the operands are newer = h[D] and older = h[D+1], where D is the delay in effect.
- R6: A requested delay above HIST_LEN-2 is treated as HIST_LEN-2.
- R7: Epochs with even index n are presented on the prompt output and epochs with odd index n on the early/late output. The two strobes are never high in the same cycle and, starting with prompt, strictly alternate.
- R8: dly_int and dly_frac are sampled only on the accepted sample that fires epoch n = 0. Each symbol has 2*CHIPS_PER_SYM epochs. Values presented on any other cycle have no effect.
- R9: The output strobe and its data appear on the second rising edge after the edge that accepted the firing sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe, four per chip |
| in_data | input | SAMP_W | Signed input sample |
| dly_int | input | DLY_W | Integer delay in input samples |
| dly_frac | input | FRAC_W | Fractional epoch, unsigned fraction of one input sample |
| prm_valid | output | 1 | Prompt sample strobe |
| prm_data | output | SAMP_W | Prompt sample value |
| el_valid | output | 1 | Early/late sample strobe |
| el_data | output | SAMP_W | Early/late sample value |

## Verification
The bound checker checks on every cycle that the two output strobes never coincide and that they alternate starting with prompt. It also checks that no strobe arrives before HIST_LEN+2 samples have been accepted and that each strobe follows an accepted sample by exactly two edges. The interpolated values can only be shown by the bench scenarios. These cover rounding at fractional epochs of zero, half and maximum, operand selection for each delay, clamping of an over-range delay, full-scale data of both signs, and idle gaps in the input. The bench also changes the timing inputs in the middle of a symbol to show that they are ignored there.

// File: rtl/lin_interp_pkg.sv
package lin_interp_pkg;

    // Sequencer states: history priming, then alternating input-pair halves
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_PAIR0 = 2'd1,
        ST_PAIR1 = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lin_interp_hist.sv
module lin_interp_hist #(
    parameter int SAMP_W = 12,
    parameter int DEPTH  = 8,
    parameter int SEL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic signed [SAMP_W-1:0] din,
    input  logic [SEL_W-1:0]         sel,
    output logic signed [SAMP_W-1:0] tap_new,
    output logic signed [SAMP_W-1:0] tap_old
);

    logic signed [SAMP_W-1:0] hreg [DEPTH];

    // Shift line: slot 0 holds the most recent sample
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hreg[0] <= '0;
                else if (push)
                    hreg[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hreg[g] <= '0;
                else if (push)
                    hreg[g] <= hreg[g-1];
            end
        end
    end

    logic [SEL_W-1:0] sel_old;
    assign sel_old = sel + SEL_W'(1);

    assign tap_new = hreg[sel];
    assign tap_old = hreg[sel_old];

endmodule

// File: rtl/lin_interp_blend.sv
module lin_interp_blend #(
    parameter int SAMP_W = 12,
    parameter int FRAC_W = 8
) (
    input  logic signed [SAMP_W-1:0] x_old,
    input  logic signed [SAMP_W-1:0] x_new,
    input  logic [FRAC_W-1:0]        mu,
    output logic signed [SAMP_W-1:0] y
);

    localparam int PW = SAMP_W + FRAC_W + 2;

    logic signed [SAMP_W:0]   diff;
    logic signed [FRAC_W:0]   mu_s;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     prod_r;
    logic signed [SAMP_W+1:0] step;
    logic signed [SAMP_W+1:0] sum;

    always_comb begin
        diff   = {x_new[SAMP_W-1], x_new} - {x_old[SAMP_W-1], x_old};
        mu_s   = {1'b0, mu};
        prod   = PW'(diff * mu_s);
        // round half up, then floor shift
        prod_r = prod + $signed({{(SAMP_W+2){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}});
        step   = prod_r[PW-1:FRAC_W];
        sum    = {{2{x_old[SAMP_W-1]}}, x_old} + step;
        y      = sum[SAMP_W-1:0];
    end

endmodule

// File: rtl/lin_interp_seq.sv
module lin_interp_seq
    import lin_interp_pkg::*;
#(
    parameter int HIST_LEN = 8,
    parameter int EPOCHS   = 8,
    parameter int DLY_W    = 3,
    parameter int FRAC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DLY_W-1:0]  dly_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              fire_q,
    output logic              late_q,
    output logic [DLY_W-1:0]  dly_q,
    output logic [FRAC_W-1:0] frac_q
);

    localparam int FCW = (HIST_LEN > 1) ? $clog2(HIST_LEN) : 1;
    localparam int NW  = $clog2(EPOCHS);
    localparam logic [DLY_W-1:0] DMAX = DLY_W'(HIST_LEN - 2);

    seq_state_e        state, state_nx;
    logic [FCW-1:0]    fill_cnt;
    logic [NW-1:0]     epoch;
    logic              fire;
    logic [DLY_W-1:0]  dly_clamp;

    assign fire      = (state == ST_PAIR1) && in_valid;
    assign dly_clamp = (dly_in > DMAX) ? DMAX : dly_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_FILL;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:  if (in_valid && fill_cnt == FCW'(HIST_LEN - 1)) state_nx = ST_PAIR0;
            ST_PAIR0: if (in_valid) state_nx = ST_PAIR1;
            ST_PAIR1: if (in_valid) state_nx = ST_PAIR0;
            default:  state_nx = ST_FILL;
        endcase
    end

    // outputs, counters and timing word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            epoch    <= '0;
            fire_q   <= 1'b0;
            late_q   <= 1'b0;
            dly_q    <= '0;
            frac_q   <= '0;
        end else begin
            fire_q <= fire;
            if (state == ST_FILL && in_valid)
                fill_cnt <= fill_cnt + FCW'(1);
            if (fire) begin
                late_q <= epoch[0];
                if (epoch == '0) begin
                    dly_q  <= dly_clamp;
                    frac_q <= frac_in;
                end
                epoch <= (epoch == NW'(EPOCHS - 1)) ? '0 : epoch + NW'(1);
            end
        end
    end

endmodule

// File: rtl/lin_interp.sv
module lin_interp #(
    parameter int SAMP_W        = 12,
    parameter int FRAC_W        = 8,
    parameter int HIST_LEN      = 8,
    parameter int CHIPS_PER_SYM = 4,
    localparam int DLY_W        = $clog2(HIST_LEN),
    localparam int EPOCHS       = 2 * CHIPS_PER_SYM
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_data,
    input  logic [DLY_W-1:0]         dly_int,
    input  logic [FRAC_W-1:0]        dly_frac,
    output logic                     prm_valid,
    output logic signed [SAMP_W-1:0] prm_data,
    output logic                     el_valid,
    output logic signed [SAMP_W-1:0] el_data
);

    logic                     fire_q;
    logic                     late_q;
    logic [DLY_W-1:0]         dly_q;
    logic [FRAC_W-1:0]        frac_q;
    logic signed [SAMP_W-1:0] tap_new;
    logic signed [SAMP_W-1:0] tap_old;
    logic signed [SAMP_W-1:0] y;

    lin_interp_seq #(
        .HIST_LEN (HIST_LEN),
        .EPOCHS   (EPOCHS),
        .DLY_W    (DLY_W),
        .FRAC_W   (FRAC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dly_in   (dly_int),
        .frac_in  (dly_frac),
        .fire_q   (fire_q),
        .late_q   (late_q),
        .dly_q    (dly_q),
        .frac_q   (frac_q)
    );

    lin_interp_hist #(
        .SAMP_W (SAMP_W),
        .DEPTH  (HIST_LEN),
        .SEL_W  (DLY_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_valid),
        .din     (in_data),
        .sel     (dly_q),
        .tap_new (tap_new),
        .tap_old (tap_old)
    );

    lin_interp_blend #(
        .SAMP_W (SAMP_W),
        .FRAC_W (FRAC_W)
    ) u_blend (
        .x_old (tap_old),
        .x_new (tap_new),
        .mu    (frac_q),
        .y     (y)
    );

    // Stream split register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prm_valid <= 1'b0;
            el_valid  <= 1'b0;
            prm_data  <= '0;
            el_data   <= '0;
        end else begin
            prm_valid <= fire_q && !late_q;
            el_valid  <= fire_q && late_q;
            if (fire_q && !late_q)
                prm_data <= y;
            if (fire_q && late_q)
                el_data <= y;
        end
    end

endmodule

// File: rtl/lin_interp_chk.sv
module lin_interp_chk #(
    parameter int HIST_LEN = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic prm_valid,
    input logic el_valid
);

    localparam int LIM = HIST_LEN + 2;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] acc_cnt;
    logic          last_el;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            last_el <= 1'b1;
        end else begin
            if (in_valid && acc_cnt < CW'(LIM))
                acc_cnt <= acc_cnt + CW'(1);
            if (prm_valid)
                last_el <= 1'b0;
            else if (el_valid)
                last_el <= 1'b1;
        end
    end

    // R7
    streams_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prm_valid && el_valid));

    // R7
    prompt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prm_valid |-> last_el);

    // R7
    late_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> !last_el);

    // R2
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prm_valid || el_valid) |-> (acc_cnt >= CW'(LIM)));

    // R9
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prm_valid || el_valid) |-> $past(in_valid, 2));

endmodule

bind lin_interp lin_interp_chk #(.HIST_LEN(HIST_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .prm_valid (prm_valid),
    .el_valid  (el_valid)
);

// File: tb/lin_interp_test.sv
module lin_interp_test;

    localparam int SW    = 12;
    localparam int FW    = 8;
    localparam int HL    = 8;
    localparam int CPS   = 4;
    localparam int DW    = $clog2(HL);
    localparam int NEP   = 2 * CPS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in_data = '0;
    logic [DW-1:0]        dly_int = '0;
    logic [FW-1:0]        dly_frac = '0;
    logic                 prm_valid;
    logic signed [SW-1:0] prm_data;
    logic                 el_valid;
    logic signed [SW-1:0] el_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int xs[$];
    int exp_prm[$];
    int exp_el[$];
    int fed = 0;
    int epoch = 0;
    int cur_d = 0;
    int cur_mu = 0;
    int seen = 0;

    always #4 clk = ~clk;

    lin_interp #(.SAMP_W(SW), .FRAC_W(FW), .HIST_LEN(HL), .CHIPS_PER_SYM(CPS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .dly_int(dly_int), .dly_frac(dly_frac),
        .prm_valid(prm_valid), .prm_data(prm_data),
        .el_valid(el_valid), .el_data(el_data)
    );

    function automatic int clampd(int d);
        return (d > HL - 2) ? HL - 2 : d;
    endfunction

    function automatic int interp(int older, int newer, int mu);
        longint p;
        p = longint'(newer - older) * mu + (longint'(1) << (FW - 1));
        return older + int'(p >>> FW);
    endfunction

    task automatic check(bit ok, string req, int got, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, expv);
        end
    endtask

    // one accepted sample; timing word driven only on the epoch-0 firing sample
    task automatic feed(int x, int d_sym, int mu_sym, bit garbage);
        bit fires, ep0;
        int older, newer, y;
        fires = (fed + 1 > HL) && (((fed + 1 - HL) % 2) == 0);
        ep0   = fires && (epoch == 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x[SW-1:0];
        if (ep0 || !garbage) begin
            dly_int  = d_sym[DW-1:0];
            dly_frac = mu_sym[FW-1:0];
        end else begin
            dly_int  = DW'($urandom);
            dly_frac = FW'($urandom);
        end
        xs.push_back(x);
        fed++;
        if (fires) begin
            if (ep0) begin
                cur_d  = clampd(d_sym);
                cur_mu = mu_sym;
            end
            newer = xs[fed - 1 - cur_d];
            older = xs[fed - 2 - cur_d];
            y = interp(older, newer, cur_mu);
            if (epoch % 2 == 0) exp_prm.push_back(y);
            else exp_el.push_back(y);
            epoch = (epoch + 1) % NEP;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    // output monitor: R4 R5 R6 R7 R8 values and stream split
    always @(negedge clk) begin
        if (rst_n) begin
            if (prm_valid && el_valid)
                check(1'b0, "R7 both strobes", 1, 0);
            if (prm_valid) begin
                seen++;
                if (exp_prm.size() == 0) check(1'b0, "R3 R7 unexpected prompt", int'(prm_data), 0);
                else begin
                    int e;
                    e = exp_prm.pop_front();
                    check(int'(prm_data) == e, "R4 R5 R6 R8 prompt value", int'(prm_data), e);
                end
            end
            if (el_valid) begin
                seen++;
                if (exp_el.size() == 0) check(1'b0, "R3 R7 unexpected early/late", int'(el_data), 0);
                else begin
                    int e;
                    e = exp_el.pop_front();
                    check(int'(el_data) == e, "R4 R5 R6 R8 early/late value", int'(el_data), e);
                end
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got=0 expected=1");
        finish_up();
    end

    initial begin
        int unused;
        unused = $urandom(32'd7331);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!prm_valid && !el_valid, "R1 strobes in reset", int'(prm_valid | el_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(prm_data == 0 && el_data == 0 && !prm_valid && !el_valid,
              "R1 outputs after reset", int'(prm_data), 0);

        // R2: fill consumes HL samples with no output
        for (int i = 0; i < HL; i++) feed(100 * (i + 1), 0, 0, 0);
        idle(4);
        check(seen == 0, "R2 no output during fill", seen, 0);

        // R9: latency of first epoch (d=0, mu=0 gives older sample, R4)
        feed(900, 0, 0, 0);
        feed(1000, 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check(!prm_valid, "R9 no strobe one edge after accept", int'(prm_valid), 0);
        @(negedge clk);
        check(prm_valid, "R9 strobe two edges after accept", int'(prm_valid), 1);
        check(int'(prm_data) == 900, "R4 mu zero gives older operand", int'(prm_data), 900);

        // rest of symbol 0 with mid-symbol garbage on the timing inputs (R8)
        for (int i = 0; i < 4 * CPS - 2; i++) feed(rnd_s(), 0, 0, 1);

        // symbol 1: over-range delay clamps (R6), half epoch, full-scale data
        for (int i = 0; i < 4 * CPS; i++)
            feed((i % 2) ? -2048 : 2047, 7, 128, 1);
        // symbol 2: max fractional epoch, delay 3
        for (int i = 0; i < 4 * CPS; i++)
            feed((i % 3 == 0) ? -2048 : 2047, 3, 255, 1);
        // symbol 3: delay 0 max epoch, steady ramp
        for (int i = 0; i < 4 * CPS; i++) feed(-7 + 5 * i, 0, 255, 0);
        idle(4);

        // random symbols with idle gaps (R3)
        for (int s = 0; s < 300; s++) begin
            int d, mu;
            d  = int'($urandom_range(0, 2 ** DW - 1));
            mu = int'($urandom_range(0, 2 ** FW - 1));
            for (int i = 0; i < 4 * CPS; i++) begin
                if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
                feed(rnd_s(), d, mu, 1);
            end
        end
        idle(6);

        // R3: every fired epoch arrived, none extra
        check(exp_prm.size() == 0, "R3 prompt epochs all delivered", exp_prm.size(), 0);
        check(exp_el.size() == 0, "R3 early/late epochs all delivered", exp_el.size(), 0);
        check(seen == (fed - HL) / 2, "R3 one epoch per two samples", seen, (fed - HL) / 2);
        check(!prm_valid && !el_valid, "R3 idle input gives no strobe", int'(prm_valid | el_valid), 0);
        finish_up();
    end

endmodule